// File: doc/BRIEF.md
# Scan-Accessible Crypto Register File

This block is the register file that sits in front of a 128-bit block-cipher engine. A simple word bus reads and writes it. The bus has an enable, a write/read select, a 5-bit word address and 32-bit data. The file holds the 128-bit key, the encrypt and decrypt source blocks, the encrypt and decrypt result blocks, and one control/status word. The cipher engine itself is outside the block. Its result blocks and done flags arrive as plain inputs and are captured every clock while the block is in normal mode.

For manufacturing test, every storage bit of the file is joined into one serial shift chain of 646 stages. The chain advances one stage per clock while the scan enable is high. A parameter mask places inverters in front of chosen stages. A pattern shifted out therefore does not show the stored bits as they are, and shifting in a pattern loads the inverse at those points. The inverters sit only on the shift path. Bus reads, bus writes and the engine-facing outputs in normal mode are unaffected by them.

Top module: `crypto_scan_regfile`

## Requirements
- R1: While reset is low every storage bit, `bus_rdata` and `scan_out` are zero.
- R2: Word addresses 0 to 3 hold the key, with address 0 holding key bits 31:0 and address 3 holding bits 127:96. `cipher_key` always shows the stored key.
- R3: Addresses 4 to 7 hold the encrypt source and addresses 12 to 15 hold the decrypt source, each with its low word at the lower address. They appear on `enc_src` and `dec_src`.
- R4: Addresses 8 to 11 (encrypt result) and 16 to 19 (decrypt result) are loaded from `enc_res` and `dec_res` on every clock while `scan_en` is low. Bus writes to them are ignored.
- R5: Address 20 reads as {26 zeros, start-decrypt, start-encrypt, start-key, decrypt-done, encrypt-done, key-done} from bit 5 down to bit 0. A write sets only bits 5:3. Bits 2:0 follow `eng_done` (bit 2 decrypt, bit 1 encrypt, bit 0 key) each normal-mode clock. `go_req` outputs bits 5:3 in that same order.
- R6: Addresses 21 to 31 read as zero, and writes to them change nothing.
- R7: A read (`bus_en` high, `bus_wr` low) returns the addressed word as it was before the edge, on `bus_rdata` one clock later. Without a read, `bus_rdata` holds its value. Reads also work while scanning.
- R8: While `scan_en` is high, each clock moves stage i+1 into stage i, and `scan_in` enters stage 645. Stage 0 is `scan_out`. Stages 5..0 are status bits 5..0. Stages 6-133 hold decrypt result bits 0-127, 134-261 encrypt result, 262-389 decrypt source, 390-517 encrypt source and 518-645 the key (key bit b at stage 518+b).
- R9: When bit i of the parameter `INV_MASK` is set, the value entering stage i during a shift is inverted.
- R10: While `scan_en` is high, bus writes are ignored and the engine inputs are not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cipher_key | output | 128 | Stored key to engine |
| enc_src | output | 128 | Encrypt source block to engine |
| dec_src | output | 128 | Decrypt source block to engine |
| go_req | output | 3 | Start bits: [2] decrypt, [1] encrypt, [0] key |
| enc_res | input | 128 | Encrypt result from engine |
| dec_res | input | 128 | Decrypt result from engine |
| eng_done | input | 3 | Done flags: [2] decrypt, [1] encrypt, [0] key |
| scan_en | input | 1 | Shift mode select |
| scan_in | input | 1 | Serial chain input |
| scan_out | output | 1 | Serial chain output (stage 0) |

## Verification
The bench goes after the following corner cases:

- **Inverter positions.** It shifts an all-zero pattern through the whole chain and reads key words back. Every bit must equal the parity of the mask from its stage up to the entry stage. A mask applied at the wrong stage, or on the exit side, gives the wrong parity.
- **Stitching order.** A random pattern goes through a full round trip. The first two shifted-out bits are also checked. A swapped field order, or a reversed bit order inside a block, puts the wrong bits on `scan_out`.
- **Bus during scan.** Writes to key word 0 and changes to the engine inputs are made during a shift. A design that lets either through corrupts the chain contents.
- **Result and status words.** Writes to the result words and to the done bits are attempted. A design that honours them returns the written value instead of the engine value.

// File: rtl/csr_scan_pkg.sv
package csr_scan_pkg;
    localparam int DW        = 32;
    localparam int BLKW      = 128;
    localparam int WPB       = BLKW / DW;
    localparam int NBLK      = 5;
    localparam int NFLAG     = 6;
    localparam int AW        = 5;
    localparam int STAT_ADDR = NBLK * WPB;
    localparam int NWORDS    = STAT_ADDR + 1;
    localparam int CHAIN_LEN = NBLK * BLKW + NFLAG;

    // status bit positions (also chain stages 0..5)
    localparam int F_KDONE = 0;
    localparam int F_EDONE = 1;
    localparam int F_DDONE = 2;
    localparam int F_SKEY  = 3;
    localparam int F_SENC  = 4;
    localparam int F_SDEC  = 5;

    localparam logic [CHAIN_LEN-1:0] DEF_INV_MASK = {2'b10, {92{7'b0010011}}};

    typedef struct packed {
        logic [BLKW-1:0]  key;
        logic [BLKW-1:0]  enc_in;
        logic [BLKW-1:0]  dec_in;
        logic [BLKW-1:0]  enc_out;
        logic [BLKW-1:0]  dec_out;
        logic [NFLAG-1:0] flags;
        logic [DW-1:0]    rdata;
    } csr_state_t;
endpackage

// File: rtl/csr_wr_decode.sv
module csr_wr_decode #(
    parameter int NW = 21,
    parameter int AW = 5
) (
    input  logic          en,
    input  logic          wr,
    input  logic          blocked,
    input  logic [AW-1:0] addr,
    output logic [NW-1:0] stb
);
    for (genvar i = 0; i < NW; i++) begin : g_stb
        assign stb[i] = en && wr && !blocked && (addr == AW'(i));
    end
endmodule

// File: rtl/csr_rd_mux.sv
module csr_rd_mux #(
    parameter int NW = 21,
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic [NW-1:0][DW-1:0] words,
    input  logic [AW-1:0]         addr,
    output logic [DW-1:0]         word
);
    always_comb begin
        word = '0;
        for (int i = 0; i < NW; i++) begin
            if (addr == AW'(i)) word = words[i];
        end
    end
endmodule

// File: rtl/csr_scan_shift.sv
module csr_scan_shift #(
    parameter int                LEN  = 646,
    parameter logic [LEN-1:0]    MASK = '0
) (
    input  logic [LEN-1:0] cur,
    input  logic           sin,
    output logic [LEN-1:0] nxt
);
    for (genvar i = 0; i < LEN; i++) begin : g_stage
        logic feed;
        if (i == LEN - 1) begin : g_head
            assign feed = sin;
        end else begin : g_body
            assign feed = cur[i+1];
        end
        if (MASK[i]) begin : g_inv
            assign nxt[i] = ~feed;
        end else begin : g_pass
            assign nxt[i] = feed;
        end
    end
endmodule

// File: rtl/crypto_scan_regfile.sv
module crypto_scan_regfile
    import csr_scan_pkg::*;
#(
    parameter logic [CHAIN_LEN-1:0] INV_MASK = DEF_INV_MASK
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_en,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic [BLKW-1:0] cipher_key,
    output logic [BLKW-1:0] enc_src,
    output logic [BLKW-1:0] dec_src,
    output logic [2:0]      go_req,
    input  logic [BLKW-1:0] enc_res,
    input  logic [BLKW-1:0] dec_res,
    input  logic [2:0]      eng_done,
    input  logic            scan_en,
    input  logic            scan_in,
    output logic            scan_out
);
    csr_state_t q, d;

    logic [NWORDS-1:0]        wr_stb;
    logic [NWORDS-1:0][DW-1:0] words;
    logic [DW-1:0]            rd_word;
    logic [CHAIN_LEN-1:0]     chain_cur;
    logic [CHAIN_LEN-1:0]     chain_nxt;

    assign chain_cur = {q.key, q.enc_in, q.dec_in, q.enc_out, q.dec_out, q.flags};

    for (genvar i = 0; i < WPB; i++) begin : g_words
        assign words[i]         = q.key[i*DW +: DW];
        assign words[WPB+i]     = q.enc_in[i*DW +: DW];
        assign words[2*WPB+i]   = q.enc_out[i*DW +: DW];
        assign words[3*WPB+i]   = q.dec_in[i*DW +: DW];
        assign words[4*WPB+i]   = q.dec_out[i*DW +: DW];
    end
    assign words[STAT_ADDR] = DW'(q.flags);

    csr_wr_decode #(.NW(NWORDS), .AW(AW)) u_dec (
        .en(bus_en), .wr(bus_wr), .blocked(scan_en), .addr(bus_addr), .stb(wr_stb)
    );

    csr_rd_mux #(.NW(NWORDS), .DW(DW), .AW(AW)) u_rd (
        .words(words), .addr(bus_addr), .word(rd_word)
    );

    csr_scan_shift #(.LEN(CHAIN_LEN), .MASK(INV_MASK)) u_shift (
        .cur(chain_cur), .sin(scan_in), .nxt(chain_nxt)
    );

    always_comb begin
        d = q;
        if (scan_en) begin
            {d.key, d.enc_in, d.dec_in, d.enc_out, d.dec_out, d.flags} = chain_nxt;
        end else begin
            for (int i = 0; i < WPB; i++) begin
                if (wr_stb[i])         d.key[i*DW +: DW]    = bus_wdata;
                if (wr_stb[WPB+i])     d.enc_in[i*DW +: DW] = bus_wdata;
                if (wr_stb[3*WPB+i])   d.dec_in[i*DW +: DW] = bus_wdata;
            end
            if (wr_stb[STAT_ADDR]) d.flags[F_SDEC:F_SKEY] = bus_wdata[F_SDEC:F_SKEY];
            d.enc_out = enc_res;
            d.dec_out = dec_res;
            d.flags[F_DDONE:F_KDONE] = eng_done;
        end
        if (bus_en && !bus_wr) d.rdata = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata  = q.rdata;
    assign cipher_key = q.key;
    assign enc_src    = q.enc_in;
    assign dec_src    = q.dec_in;
    assign go_req     = q.flags[F_SDEC:F_SKEY];
    assign scan_out   = q.flags[F_KDONE];

    AST_SCAN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> (cipher_key[BLKW-1] == ($past(scan_in) ^ INV_MASK[CHAIN_LEN-1]))); // R9
    AST_SCAN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> (scan_out == ($past(chain_cur[1]) ^ INV_MASK[0]))); // R8
    AST_RES_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> (q.enc_out == $past(enc_res)) && (q.dec_out == $past(dec_res))); // R4
    AST_DONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> (q.flags[F_DDONE:F_KDONE] == $past(eng_done))); // R5
    AST_HIGH_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_wr && (bus_addr >= AW'(NWORDS))) |=> (bus_rdata == '0)); // R6
    AST_KEY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && !(bus_en && bus_wr && (bus_addr < AW'(WPB)))) |=> $stable(cipher_key)); // R2
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && !bus_wr) |=> $stable(bus_rdata)); // R7
endmodule

// File: tb/sim_crypto_scan_regfile.sv
module sim_crypto_scan_regfile;
    import csr_scan_pkg::*;

    localparam int CLK_PER = 10;
    localparam logic [CHAIN_LEN-1:0] TB_MASK = {2'b01, {92{7'b1001101}}};

    logic            clk = 0;
    logic            rst_n = 0;
    logic            bus_en = 0, bus_wr = 0;
    logic [AW-1:0]   bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;
    logic [BLKW-1:0] cipher_key, enc_src, dec_src;
    logic [2:0]      go_req;
    logic [BLKW-1:0] enc_res = '0, dec_res = '0;
    logic [2:0]      eng_done = '0;
    logic            scan_en = 0, scan_in = 0;
    logic            scan_out;

    int total = 0, bad = 0;
    bit cmp_on = 0;
    string cur_req = "R1";

    crypto_scan_regfile #(.INV_MASK(TB_MASK)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cipher_key(cipher_key),
        .enc_src(enc_src), .dec_src(dec_src), .go_req(go_req), .enc_res(enc_res),
        .dec_res(dec_res), .eng_done(eng_done), .scan_en(scan_en), .scan_in(scan_in),
        .scan_out(scan_out)
    );

    always #(CLK_PER/2) clk = ~clk;

    // behavioural reference model
    logic [127:0] mk, mei, mdi, meo, mdo;
    logic [5:0]   mf;
    logic [31:0]  mrd;
    logic [CHAIN_LEN-1:0] mch, mnx;

    function automatic logic [31:0] mword(input int a);
        if (a < 4)       return mk[a*32 +: 32];
        else if (a < 8)  return mei[(a-4)*32 +: 32];
        else if (a < 12) return meo[(a-8)*32 +: 32];
        else if (a < 16) return mdi[(a-12)*32 +: 32];
        else if (a < 20) return mdo[(a-16)*32 +: 32];
        else if (a == 20) return {26'b0, mf};
        return 32'h0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mk = '0; mei = '0; mdi = '0; meo = '0; mdo = '0; mf = '0; mrd = '0;
        end else begin
            if (bus_en && !bus_wr) mrd = mword(int'(bus_addr));
            if (scan_en) begin
                mch = {mk, mei, mdi, meo, mdo, mf};
                for (int i = 0; i < CHAIN_LEN-1; i++) mnx[i] = mch[i+1] ^ TB_MASK[i];
                mnx[CHAIN_LEN-1] = scan_in ^ TB_MASK[CHAIN_LEN-1];
                {mk, mei, mdi, meo, mdo, mf} = mnx;
            end else begin
                if (bus_en && bus_wr) begin
                    int a;
                    a = int'(bus_addr);
                    if (a < 4) mk[a*32 +: 32] = bus_wdata;
                    else if (a >= 4 && a < 8) mei[(a-4)*32 +: 32] = bus_wdata;
                    else if (a >= 12 && a < 16) mdi[(a-12)*32 +: 32] = bus_wdata;
                    else if (a == 20) mf[5:3] = bus_wdata[5:3];
                end
                meo = enc_res; mdo = dec_res; mf[2:0] = eng_done;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(bus_rdata == mrd, cur_req, "rdata", 128'(bus_rdata), 128'(mrd));
            chk(scan_out == mf[0], cur_req, "scan_out", 128'(scan_out), 128'(mf[0]));
            chk(cipher_key == mk, cur_req, "cipher_key", cipher_key, mk);
            chk(enc_src == mei, cur_req, "enc_src", enc_src, mei);
            chk(dec_src == mdi, cur_req, "dec_src", dec_src, mdi);
            chk(go_req == mf[5:3], cur_req, "go_req", 128'(go_req), 128'(mf[5:3]));
        end
    end

    task automatic bwrite(input int a, input logic [31:0] v);
        @(negedge clk); bus_en = 1; bus_wr = 1; bus_addr = AW'(a); bus_wdata = v;
        @(negedge clk); bus_en = 0;
    endtask

    task automatic bread(input int a, output logic [31:0] v);
        @(negedge clk); bus_en = 1; bus_wr = 0; bus_addr = AW'(a);
        @(negedge clk); bus_en = 0; v = bus_rdata;
    endtask

    function automatic logic par_from(input int s);
        logic r = 0;
        for (int j = s; j < CHAIN_LEN; j++) r ^= TB_MASK[j];
        return r;
    endfunction

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL %s watchdog expired act=1 exp=0", cur_req);
        finish_run();
    end

    initial begin
        logic [31:0] v, e;
        logic [CHAIN_LEN-1:0] pat;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(bus_rdata == 0 && scan_out == 0 && cipher_key == 0, "R1", "reset",
            128'(bus_rdata), 128'h0);
        rst_n = 1;
        @(negedge clk);
        cmp_on = 1;

        // R2 key words
        cur_req = "R2";
        bwrite(0, 32'h0123_4567); bwrite(1, 32'h89ab_cdef);
        bwrite(2, 32'hdead_beef); bwrite(3, 32'h0f1e_2d3c);
        chk(cipher_key == 128'h0f1e2d3c_deadbeef_89abcdef_01234567, "R2", "key out",
            cipher_key, 128'h0f1e2d3c_deadbeef_89abcdef_01234567);
        bread(2, v);
        chk(v == 32'hdead_beef, "R2", "key word 2", 128'(v), 128'hdeadbeef);

        // R3 source blocks
        cur_req = "R3";
        bwrite(5, 32'ha5a5_0001); bwrite(15, 32'h7777_aaaa);
        chk(enc_src[63:32] == 32'ha5a5_0001, "R3", "enc src w1", 128'(enc_src[63:32]), 128'ha5a50001);
        chk(dec_src[127:96] == 32'h7777_aaaa, "R3", "dec src w3", 128'(dec_src[127:96]), 128'h7777aaaa);
        bread(15, v);
        chk(v == 32'h7777_aaaa, "R3", "read 15", 128'(v), 128'h7777aaaa);

        // R4 result blocks follow engine, writes ignored
        cur_req = "R4";
        enc_res = 128'h11112222_33334444_55556666_77778888;
        dec_res = 128'h9999aaaa_bbbbcccc_ddddeeee_ffff0000;
        bwrite(9, 32'hffff_ffff);
        bread(9, v);
        chk(v == 32'h5555_6666, "R4", "enc result w1", 128'(v), 128'h55556666);
        bread(19, v);
        chk(v == 32'h9999_aaaa, "R4", "dec result w3", 128'(v), 128'h9999aaaa);

        // R5 status word
        cur_req = "R5";
        eng_done = 3'b010;
        bwrite(20, 32'h0000_003f);
        bread(20, v);
        chk(v == 32'h0000_003a, "R5", "status", 128'(v), 128'h3a);
        chk(go_req == 3'b111, "R5", "go_req", 128'(go_req), 128'h7);
        bwrite(20, 32'h0000_0005);
        bread(20, v);
        chk(v == 32'h0000_0002, "R5", "status clear", 128'(v), 128'h2);

        // R6 unmapped addresses
        cur_req = "R6";
        bwrite(25, 32'hffff_ffff);
        bread(25, v);
        chk(v == 0, "R6", "read 25", 128'(v), 128'h0);
        bread(31, v);
        chk(v == 0, "R6", "read 31", 128'(v), 128'h0);
        bread(0, v);
        chk(v == 32'h0123_4567, "R6", "key w0 untouched", 128'(v), 128'h01234567);

        // R7 read data holds
        cur_req = "R7";
        bread(2, v);
        enc_res = ~enc_res;
        repeat (3) @(negedge clk);
        chk(bus_rdata == 32'hdead_beef, "R7", "rdata hold", 128'(bus_rdata), 128'hdeadbeef);

        // R8/R9/R10 zero pattern through chain; status now 000010
        cur_req = "R10";
        for (int k = 0; k < CHAIN_LEN; k++) begin
            @(negedge clk);
            if (k == 1) chk(scan_out == (1'b1 ^ TB_MASK[0]), "R8", "first shift", 128'(scan_out),
                            128'(1'b1 ^ TB_MASK[0]));
            if (k == 2) chk(scan_out == (TB_MASK[1] ^ TB_MASK[0]), "R8", "second shift",
                            128'(scan_out), 128'(TB_MASK[1] ^ TB_MASK[0]));
            scan_en = 1; scan_in = 0;
            enc_res = {$urandom, $urandom, $urandom, $urandom};
            eng_done = 3'($urandom);
            if (k == 5) begin bus_en = 1; bus_wr = 1; bus_addr = 0; bus_wdata = '1; end
            else bus_en = 0;
        end
        @(negedge clk); scan_en = 0; bus_en = 0;
        bread(1, v);
        for (int b = 0; b < 32; b++) e[b] = par_from(518 + 32 + b);
        chk(v == e, "R9", "key w1 after zero scan", 128'(v), 128'(e));
        bread(0, v);
        for (int b = 0; b < 32; b++) e[b] = par_from(518 + b);
        chk(v == e, "R10", "key w0 write during scan", 128'(v), 128'(e));

        // R8 random pattern round trip
        cur_req = "R8";
        for (int k = 0; k < CHAIN_LEN; k++) pat[k] = 1'($urandom);
        for (int k = 0; k < CHAIN_LEN; k++) begin
            @(negedge clk); scan_en = 1; scan_in = pat[k];
        end
        @(negedge clk); scan_en = 0;
        bread(3, v);
        for (int b = 0; b < 32; b++) e[b] = pat[614 + b] ^ par_from(614 + b);
        chk(v == e, "R8", "key w3 after pattern", 128'(v), 128'(e));

        // mixed traffic
        cur_req = "R4";
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            bus_en = 1'($urandom); bus_wr = 1'($urandom);
            bus_addr = AW'($urandom); bus_wdata = $urandom;
            scan_en = ($urandom % 4) == 0; scan_in = 1'($urandom);
            dec_res = {$urandom, $urandom, $urandom, $urandom};
            eng_done = 3'($urandom);
        end
        @(negedge clk); bus_en = 0; scan_en = 0;
        @(negedge clk);
        finish_run();
    end
endmodule